// File: doc/BRIEF.md
# Shared-Window Memory Decoder for a Master and Application Processors

This block sits between one master processor, up to four application processors and the small memories that link them. Every processor sees a 16-bit data address space. The lowest 256 words go to a private data RAM. Every master/application pair shares two 128-word windows. In one window only the master writes. In the other only the application processor writes. Both sides can read both windows. Each window has one write port and two independent read ports, so the two sides never contend for a read.

The decoder turns each processor's address into a local-RAM access or a window access. It gates the window write enables so that only the owning side can write. It multiplexes the read data back to the requesting port. It flags writes that are not allowed. Every access finishes in one cycle, so there is no back-pressure. The request pins (`*_en`, `*_we`, address, write data) are plain pins with no valid/ready handshake. An access is accepted in every cycle in which its enable is high.

Top module: `smx_fabric`

## Requirements
- R1: In the master address map, page 0x00 (0x0000–0x00FF) is its local RAM. Page k (k = 1..N_AP) belongs to application processor k. Offsets 0x00–0x7F of that page form the master's writable outbound window, and offsets 0x80–0xFF form the read-only inbound window. The master can also read its own outbound window.
- R2: In an application processor's map, page 0x00 is its local RAM. Offsets 0x00–0x7F of page 0x01 are the read-only window from the master. Offsets 0x80–0xFF of page 0x01 are its own writable window toward the master.
- R3: A word that the owner writes into a window can be read by both sides at the same window offset. Each pair's windows are separate from every other pair's windows.
- R4: A write into a read-only window is dropped, and the window contents stay unchanged. The writing port's error flag goes high on the next cycle.
- R5: A read from an address outside the port's map returns zero. A write to such an address is dropped and sets that port's error flag.
- R6: Error flags are sticky until reset. Legal writes never set them.
- R7: Read data appears on a port's `rdata` on the cycle after the read request. It holds until that port issues its next read. Write and idle cycles leave it unchanged.
- R8: Suppose the owner writes a window word and the other side reads the same word in the same cycle. The read returns the old contents, and the new value is visible from the next read on.
- R9: Local RAMs are private. The same local address on different ports holds independent data.
- R10: During and after reset, every `rdata` is zero and every error flag is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| m_en | input | 1 | Master access enable |
| m_we | input | 1 | Master write (1) or read (0) |
| m_addr | input | 16 | Master data address |
| m_wdata | input | DW | Master write data |
| m_rdata | output | DW | Master read data, one cycle after the read |
| m_werr | output | 1 | Master sticky illegal-write flag |
| ap_en | input | N_AP | Per-application-processor access enable |
| ap_we | input | N_AP | Per-application-processor write select |
| ap_addr | input | 16*N_AP | Addresses; processor k uses slice [16k+15:16k] |
| ap_wdata | input | DW*N_AP | Write data, slice k per processor |
| ap_rdata | output | DW*N_AP | Read data, slice k per processor |
| ap_werr | output | N_AP | Per-processor sticky illegal-write flags |

## Verification
The assertions assume that after reset the enable and write-select pins always carry known values and that each port issues at most one access per cycle. The bench drives only defined levels. It releases enables as soon as each access cycle ends. It reads a window or local word only after writing that word, so no uninitialised memory contents reach a compared output. The stimulus covers illegal writes and unmapped reads on both the master and the application side, and it checks them through the flags and through later reads.

// File: rtl/smx_pkg.sv
package smx_pkg;
  localparam int ADDR_W    = 16;
  localparam int LOC_AW    = 8;   // 256-word local RAM
  localparam int WIN_AW    = 7;   // 128-word shared window
  localparam int MAX_PAIRS = 4;
  localparam int IDX_W     = $clog2(MAX_PAIRS);

  typedef enum logic [1:0] {
    RG_NONE  = 2'd0,
    RG_LOCAL = 2'd1,
    RG_OWN   = 2'd2,   // window this port may write
    RG_PEER  = 2'd3    // window this port may only read
  } region_e;

  typedef struct packed {
    region_e          kind;
    logic [IDX_W-1:0] idx;
  } hit_t;

  // Page = address bits [15:8]; bit 7 picks the half of a pair page.
  function automatic hit_t map_addr(input logic is_master,
                                    input int unsigned n_pair,
                                    input logic [ADDR_W-1:0] a);
    hit_t h;
    h.kind = RG_NONE;
    h.idx  = '0;
    if (a[15:8] == 8'h00) begin
      h.kind = RG_LOCAL;
    end else if (is_master) begin
      if (32'(a[15:8]) <= n_pair) begin
        h.idx  = IDX_W'(a[15:8] - 8'd1);
        h.kind = a[7] ? RG_PEER : RG_OWN;
      end
    end else if (a[15:8] == 8'h01) begin
      h.kind = a[7] ? RG_OWN : RG_PEER;
    end
    return h;
  endfunction
endpackage

// File: rtl/smx_lram.sv
module smx_lram #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) q <= mem[addr];
  end
endmodule

// File: rtl/smx_win.sv
// One write port, two independent registered read ports.
module smx_win #(
  parameter int AW = 7,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re_a,
  input  logic [AW-1:0] addr_a,
  output logic [DW-1:0] q_a,
  input  logic          re_b,
  input  logic [AW-1:0] addr_b,
  output logic [DW-1:0] q_b
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  // Reads sample the array before this edge's write lands: old data.
  always_ff @(posedge clk) begin
    if (we)   mem[waddr] <= wdata;
    if (re_a) q_a <= mem[addr_a];
    if (re_b) q_b <= mem[addr_b];
  end
endmodule

// File: rtl/smx_port.sv
module smx_port
  import smx_pkg::*;
#(
  parameter bit IS_MASTER = 1'b1,
  parameter int N_PAIR    = 1,
  parameter int DW        = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  output logic              werr,
  output logic [WIN_AW-1:0] win_addr,
  output logic [DW-1:0]     win_wdata,
  output logic [N_PAIR-1:0] own_we,
  output logic [N_PAIR-1:0] own_re,
  output logic [N_PAIR-1:0] peer_re,
  input  logic [DW-1:0]     own_q  [N_PAIR],
  input  logic [DW-1:0]     peer_q [N_PAIR]
);
  hit_t hit;
  logic wr, rd, bad_wr;
  logic [DW-1:0] loc_q;
  region_e sel_kind;
  logic [IDX_W-1:0] sel_idx;

  assign hit       = map_addr(IS_MASTER, N_PAIR, addr);
  assign wr        = en && we;
  assign rd        = en && !we;
  assign bad_wr    = wr && (hit.kind == RG_PEER || hit.kind == RG_NONE);
  assign win_addr  = addr[WIN_AW-1:0];
  assign win_wdata = wdata;

  smx_lram #(.AW(LOC_AW), .DW(DW)) u_lram (
    .clk   (clk),
    .we    (wr && hit.kind == RG_LOCAL),
    .re    (rd && hit.kind == RG_LOCAL),
    .addr  (addr[LOC_AW-1:0]),
    .wdata (wdata),
    .q     (loc_q)
  );

  for (genvar j = 0; j < N_PAIR; j++) begin : g_pair
    localparam logic [IDX_W-1:0] J = IDX_W'(j);
    assign own_we[j]  = wr && hit.kind == RG_OWN  && hit.idx == J;
    assign own_re[j]  = rd && hit.kind == RG_OWN  && hit.idx == J;
    assign peer_re[j] = rd && hit.kind == RG_PEER && hit.idx == J;
  end

  // Remember where the last read went so the next cycle can steer it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_kind <= RG_NONE;
      sel_idx  <= '0;
      werr     <= 1'b0;
    end else begin
      if (rd) begin
        sel_kind <= hit.kind;
        sel_idx  <= hit.idx;
      end
      if (bad_wr) werr <= 1'b1;
    end
  end

  always_comb begin
    rdata = '0;
    case (sel_kind)
      RG_LOCAL: rdata = loc_q;
      RG_OWN: begin
        for (int j = 0; j < N_PAIR; j++)
          if (sel_idx == IDX_W'(j)) rdata = own_q[j];
      end
      RG_PEER: begin
        for (int j = 0; j < N_PAIR; j++)
          if (sel_idx == IDX_W'(j)) rdata = peer_q[j];
      end
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/smx_fabric.sv
module smx_fabric
  import smx_pkg::*;
#(
  parameter int N_AP = 2,
  parameter int DW   = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   m_en,
  input  logic                   m_we,
  input  logic [ADDR_W-1:0]      m_addr,
  input  logic [DW-1:0]          m_wdata,
  output logic [DW-1:0]          m_rdata,
  output logic                   m_werr,
  input  logic [N_AP-1:0]        ap_en,
  input  logic [N_AP-1:0]        ap_we,
  input  logic [N_AP*ADDR_W-1:0] ap_addr,
  input  logic [N_AP*DW-1:0]     ap_wdata,
  output logic [N_AP*DW-1:0]     ap_rdata,
  output logic [N_AP-1:0]        ap_werr
);
  if (N_AP < 1 || N_AP > MAX_PAIRS) begin : g_bad_cfg
    $error("smx_fabric: N_AP out of range");
  end

  logic [WIN_AW-1:0] m_win_addr;
  logic [DW-1:0]     m_win_wdata;
  logic [N_AP-1:0]   m_own_we, m_own_re, m_peer_re;
  logic [DW-1:0]     m_own_q  [N_AP];
  logic [DW-1:0]     m_peer_q [N_AP];

  smx_port #(.IS_MASTER(1'b1), .N_PAIR(N_AP), .DW(DW)) u_mport (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (m_en),
    .we        (m_we),
    .addr      (m_addr),
    .wdata     (m_wdata),
    .rdata     (m_rdata),
    .werr      (m_werr),
    .win_addr  (m_win_addr),
    .win_wdata (m_win_wdata),
    .own_we    (m_own_we),
    .own_re    (m_own_re),
    .peer_re   (m_peer_re),
    .own_q     (m_own_q),
    .peer_q    (m_peer_q)
  );

  for (genvar k = 0; k < N_AP; k++) begin : g_ap
    logic [WIN_AW-1:0] a_win_addr;
    logic [DW-1:0]     a_win_wdata;
    logic [0:0]        a_own_we, a_own_re, a_peer_re;
    logic [DW-1:0]     a_own_q  [1];
    logic [DW-1:0]     a_peer_q [1];
    logic [DW-1:0]     dn_qa, dn_qb, up_qa, up_qb;

    smx_port #(.IS_MASTER(1'b0), .N_PAIR(1), .DW(DW)) u_aport (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (ap_en[k]),
      .we        (ap_we[k]),
      .addr      (ap_addr[k*ADDR_W +: ADDR_W]),
      .wdata     (ap_wdata[k*DW +: DW]),
      .rdata     (ap_rdata[k*DW +: DW]),
      .werr      (ap_werr[k]),
      .win_addr  (a_win_addr),
      .win_wdata (a_win_wdata),
      .own_we    (a_own_we),
      .own_re    (a_own_re),
      .peer_re   (a_peer_re),
      .own_q     (a_own_q),
      .peer_q    (a_peer_q)
    );

    // Master-owned window toward processor k.
    smx_win #(.AW(WIN_AW), .DW(DW)) u_down (
      .clk    (clk),
      .we     (m_own_we[k]),
      .waddr  (m_win_addr),
      .wdata  (m_win_wdata),
      .re_a   (m_own_re[k]),
      .addr_a (m_win_addr),
      .q_a    (dn_qa),
      .re_b   (a_peer_re[0]),
      .addr_b (a_win_addr),
      .q_b    (dn_qb)
    );

    // Processor-k-owned window toward the master.
    smx_win #(.AW(WIN_AW), .DW(DW)) u_up (
      .clk    (clk),
      .we     (a_own_we[0]),
      .waddr  (a_win_addr),
      .wdata  (a_win_wdata),
      .re_a   (m_peer_re[k]),
      .addr_a (m_win_addr),
      .q_a    (up_qa),
      .re_b   (a_own_re[0]),
      .addr_b (a_win_addr),
      .q_b    (up_qb)
    );

    assign m_own_q[k]  = dn_qa;
    assign m_peer_q[k] = up_qa;
    assign a_own_q[0]  = up_qb;
    assign a_peer_q[0] = dn_qb;
  end
endmodule

// File: rtl/smx_fabric_chk.sv
module smx_fabric_chk
  import smx_pkg::*;
#(
  parameter int N_AP = 2,
  parameter int DW   = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   m_en,
  input logic                   m_we,
  input logic [ADDR_W-1:0]      m_addr,
  input logic [DW-1:0]          m_rdata,
  input logic                   m_werr,
  input logic [N_AP-1:0]        ap_en,
  input logic [N_AP-1:0]        ap_we,
  input logic [N_AP*ADDR_W-1:0] ap_addr,
  input logic [N_AP*DW-1:0]     ap_rdata,
  input logic [N_AP-1:0]        ap_werr
);
  assert_werr_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    m_werr |=> m_werr);

  assert_ap_werr_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ap_werr[0] |=> ap_werr[0]);

  assert_legal_write_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!m_werr && m_en && m_we && m_addr[15:8] == 8'h00) |=> !m_werr);

  assert_m_ro_write_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (m_en && m_we && m_addr[15:8] == 8'h01 && m_addr[7]) |=> m_werr);

  assert_ap_ro_write_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ap_en[0] && ap_we[0] && ap_addr[15:8] == 8'h01 && !ap_addr[7]) |=> ap_werr[0]);

  assert_unmapped_read_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (m_en && !m_we && 32'(m_addr[15:8]) > N_AP) |=> (m_rdata == '0));

  assert_ap_unmapped_read_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ap_en[0] && !ap_we[0] && ap_addr[15:8] > 8'h01) |=> (ap_rdata[DW-1:0] == '0));

  assert_rdata_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(m_en && !m_we) |=> $stable(m_rdata));
endmodule

bind smx_fabric smx_fabric_chk #(.N_AP(N_AP), .DW(DW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .m_en     (m_en),
  .m_we     (m_we),
  .m_addr   (m_addr),
  .m_rdata  (m_rdata),
  .m_werr   (m_werr),
  .ap_en    (ap_en),
  .ap_we    (ap_we),
  .ap_addr  (ap_addr),
  .ap_rdata (ap_rdata),
  .ap_werr  (ap_werr)
);

// File: tb/tb_smx_fabric.sv
module tb_smx_fabric;
  import smx_pkg::*;
  localparam int N_AP = 2;
  localparam int DW   = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  logic                   m_en = 0, m_we = 0;
  logic [ADDR_W-1:0]      m_addr = '0;
  logic [DW-1:0]          m_wdata = '0;
  logic [DW-1:0]          m_rdata;
  logic                   m_werr;
  logic [N_AP-1:0]        ap_en = '0, ap_we = '0;
  logic [N_AP*ADDR_W-1:0] ap_addr = '0;
  logic [N_AP*DW-1:0]     ap_wdata = '0;
  logic [N_AP*DW-1:0]     ap_rdata;
  logic [N_AP-1:0]        ap_werr;

  smx_fabric #(.N_AP(N_AP), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n),
    .m_en(m_en), .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata),
    .m_rdata(m_rdata), .m_werr(m_werr),
    .ap_en(ap_en), .ap_we(ap_we), .ap_addr(ap_addr), .ap_wdata(ap_wdata),
    .ap_rdata(ap_rdata), .ap_werr(ap_werr)
  );

  typedef struct {
    int            who;   // 0 = master, k+1 = application processor k
    logic [DW-1:0] val;
    string         tag;
  } exp_t;

  exp_t exp_q[$];
  int n_fire = 0;
  int pend = 0;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  function automatic logic [DW-1:0] port_rd(input int who);
    if (who == 0) return m_rdata;
    return ap_rdata[(who-1)*DW +: DW];
  endfunction

  task automatic chk(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: reads fired in the cycle before an edge are compared at the
  // negedge that follows it.
  always @(negedge clk) begin
    exp_t e;
    for (int i = 0; i < pend; i++) begin
      if (exp_q.size() != 0) begin
        e = exp_q.pop_front();
        chk(port_rd(e.who), e.val, e.tag);
      end
    end
    pend = n_fire;
  end

  task automatic m_op(input logic w, input logic [15:0] a, input logic [DW-1:0] d);
    m_en = 1'b1; m_we = w; m_addr = a; m_wdata = d;
  endtask

  task automatic a_op(input int k, input logic w, input logic [15:0] a, input logic [DW-1:0] d);
    ap_en[k] = 1'b1; ap_we[k] = w;
    ap_addr[k*ADDR_W +: ADDR_W] = a;
    ap_wdata[k*DW +: DW] = d;
  endtask

  task automatic expect_rd(input int who, input logic [DW-1:0] v, input string tag);
    exp_t e;
    e.who = who; e.val = v; e.tag = tag;
    exp_q.push_back(e);
    n_fire++;
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    m_en = 1'b0; m_we = 1'b0;
    ap_en = '0; ap_we = '0;
    n_fire = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(4 * 20000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    // R10: reset state
    chk(m_rdata, '0, "R10 master rdata in reset");
    chk(ap_rdata[DW-1:0], '0, "R10 ap0 rdata in reset");
    chk(DW'({m_werr, ap_werr}), '0, "R10 flags in reset");
    #1 rst_n = 1'b1;
    step();

    // R9: private local RAMs, written in parallel
    m_op(1, 16'h0010, 16'hA5A5);
    a_op(0, 1, 16'h0010, 16'h5A5A);
    a_op(1, 1, 16'h0010, 16'h0F0F);
    step();
    m_op(0, 16'h0010, '0);       expect_rd(0, 16'hA5A5, "R9 R1 master local");
    a_op(0, 0, 16'h0010, '0);    expect_rd(1, 16'h5A5A, "R9 R2 ap0 local");
    a_op(1, 0, 16'h0010, '0);    expect_rd(2, 16'h0F0F, "R9 ap1 local");
    step();

    // Owner writes into windows
    m_op(1, 16'h0105, 16'h1234);
    a_op(0, 1, 16'h0185, 16'hBEEF);
    a_op(1, 1, 16'h0180, 16'hC0DE);
    step();
    m_op(1, 16'h0205, 16'h5678);
    step();
    m_op(1, 16'h0107, 16'h1111);
    step();

    // R3 / R1 / R2: each side reads
    m_op(0, 16'h0185, '0);       expect_rd(0, 16'hBEEF, "R3 master reads ap0 window");
    a_op(0, 0, 16'h0105, '0);    expect_rd(1, 16'h1234, "R3 ap0 reads master window");
    a_op(1, 0, 16'h0105, '0);    expect_rd(2, 16'h5678, "R3 ap1 reads its own pair");
    step();
    m_op(0, 16'h0280, '0);       expect_rd(0, 16'hC0DE, "R1 master page 2 inbound");
    a_op(0, 0, 16'h0185, '0);    expect_rd(1, 16'hBEEF, "R2 ap0 reads own window");
    a_op(1, 0, 16'h0180, '0);    expect_rd(2, 16'hC0DE, "R2 ap1 reads own window");
    step();
    m_op(0, 16'h0105, '0);       expect_rd(0, 16'h1234, "R1 master reads own outbound");
    step();
    chk(DW'({m_werr, ap_werr}), '0, "R6 no flag after legal writes");

    // R4: writes into read-only windows
    m_op(1, 16'h0185, 16'h0000);
    a_op(0, 1, 16'h0105, 16'h0000);
    step();
    chk(DW'(m_werr), 16'h1, "R4 master flag");
    chk(DW'(ap_werr[0]), 16'h1, "R4 ap0 flag");
    chk(DW'(ap_werr[1]), 16'h0, "R4 ap1 flag untouched");
    m_op(0, 16'h0185, '0);       expect_rd(0, 16'hBEEF, "R4 ap0 window unchanged");
    a_op(0, 0, 16'h0105, '0);    expect_rd(1, 16'h1234, "R4 master window unchanged");
    step();

    // R5: unmapped accesses
    m_op(0, 16'h0300, '0);       expect_rd(0, 16'h0000, "R5 master unmapped read");
    a_op(0, 0, 16'h0200, '0);    expect_rd(1, 16'h0000, "R5 ap0 unmapped read");
    a_op(1, 1, 16'h0290, 16'hFFFF);
    step();
    chk(DW'(ap_werr[1]), 16'h1, "R5 ap1 unmapped write flag");

    // R8: same-cycle write and read of one word
    m_op(1, 16'h0107, 16'h2222);
    a_op(0, 0, 16'h0107, '0);    expect_rd(1, 16'h1111, "R8 old contents");
    step();
    a_op(0, 0, 16'h0107, '0);    expect_rd(1, 16'h2222, "R8 new contents next read");
    step();

    // R7: hold across write and idle cycles
    m_op(0, 16'h0010, '0);       expect_rd(0, 16'hA5A5, "R7 read");
    step();
    m_op(1, 16'h0011, 16'h9999);
    step();
    step();
    chk(m_rdata, 16'hA5A5, "R7 held through write and idle");
    m_op(0, 16'h0011, '0);       expect_rd(0, 16'h9999, "R7 next read updates");
    step();

    // R6: flags remain set
    chk(DW'(m_werr), 16'h1, "R6 master flag sticky");
    chk(DW'(ap_werr), 16'h3, "R6 ap flags sticky");
    step();
    step();
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL scoreboard actual=%0d expected=0 pending", exp_q.size());
    end
    finish_run();
  end
endmodule